// File: doc/BRIEF.md
# SDRAM Data-Path Timing Unit

This block sits on the controller side of a 16-bit SDRAM data bus, between the logic that issues commands and the pad drivers. Each cycle it is told which column command goes to the memory: idle, read, write or burst stop. It also gets the CAS latency (2 or 3) and the burst length that apply to that command. From these it works out three things. First, the cycles in which read data arrives and which of its bytes may be captured. Second, the cycles in which the controller must drive write data. Third, the per-byte mask pins. It also handles a new command that cuts a burst short, and it keeps read and write data from meeting on the bus.

Write data comes in as a stream. `wd_ready` is high in each write beat, and the word on `wd_data` goes onto the bus in that cycle. The memory cannot wait, so the stream cannot push back on the beat schedule. A beat that finds `wd_valid` low is still spent, and the block masks both bytes of that beat so that nothing is written. Read data goes out with `rd_valid` and per-byte `rd_lane` qualifiers and has no ready: the consumer must take it in the cycle it appears. A write that would meet read data still in flight is refused. `wr_clear` tells the issuer in advance whether a write issued now would be accepted.

Top module: `sdram_dp_timer`

## Requirements
- R1: A READ issued in cycle t with burst code k raises `rd_valid` in cycles t+L through t+L+2^k-1, where L is its CAS latency. The burst codes 0, 1, 2 and 3 select 1, 2, 4 and 8 words. `rd_valid` is high for every word that is due, masked or not.
- R2: `cas3` = 0 selects latency 2 and `cas3` = 1 selects latency 3. The value sampled with each READ sets that burst's timing.
- R3: A WRITE accepted in cycle t holds `dq_oe` and `wd_ready` high in cycles t through t+2^k-1, with `dq_out` equal to `wd_data` in each of those cycles.
- R4: In a write beat, `dqm` takes effect in that same cycle: `dqm` = `wmask` OR'ed with the inverse of `wd_valid` on both bits. Bit 0 guards data bits 7:0 and bit 1 guards bits 15:8.
- R5: During reads, `dqm` bit i high in cycle c disables byte lane i of the word due in cycle c+2. `rd_lane[i]` is 0 and that byte of `rd_data` reads 0. An enabled lane passes `dq_in` through.
- R6: A READ issued while a read burst is running keeps the old words due before t+L and drops all later ones. The new burst starts at t+L.
- R7: A burst stop in cycle t keeps the read words due before t+L and drops every later one.
- R8: A READ or burst stop in cycle t ends a running write burst: `dq_oe` is low from cycle t on.
- R9: A WRITE accepted during a write burst restarts the beat count: a full new burst begins in cycle t.
- R10: `wr_clear` is low when any of these read words is due and not fully masked: one due now with any `dqm` bit low two cycles back, or one due next cycle with any `dqm` bit low one cycle back. It is also low at latency 3 when a word is due two cycles ahead. A WRITE issued while `wr_clear` is low is ignored: no write beats, and the read schedule is unchanged.
- R11: `dq_oe` and any `rd_lane` bit are never high in the same cycle.
- R12: While reset is asserted, `rd_valid`, `rd_lane`, `dq_oe` and `wd_ready` are low and `wr_clear` is high.
- R13: Outside write beats, `dqm` equals `rmask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_op | input | 2 | Command in this cycle: 0 idle, 1 read, 2 write, 3 burst stop |
| cas3 | input | 1 | CAS latency select: 0 for 2, 1 for 3 |
| bl_code | input | 2 | Burst length code, 2^code words |
| rmask | input | 2 | Byte masks requested during reads |
| wd_data | input | 16 | Write data stream word |
| wd_valid | input | 1 | Write data stream valid |
| wd_ready | output | 1 | Write beat in this cycle (word consumed) |
| wmask | input | 2 | Byte write masks for the current beat |
| dq_out | output | 16 | Data to drive on the bus |
| dq_oe | output | 1 | Drive enable for the data bus |
| dqm | output | 2 | Mask pins to the memory |
| dq_in | input | 16 | Data seen on the bus |
| rd_data | output | 16 | Read word with disabled lanes zeroed |
| rd_lane | output | 2 | Per-byte capture strobe |
| rd_valid | output | 1 | A read word is due this cycle |
| wr_clear | output | 1 | A write issued now would be accepted |

## Verification
The bench targets interrupts at every offset. A design that did not truncate correctly would let old words leak past the new burst's start, or would cut off words already in the memory's output pipe. Read-to-write turnarounds are driven with masks raised one and two cycles ahead. A wrong mask latency would blank the wrong word or accept a write into live read data. Writes issued too early must be refused, and write beats with the stream empty must raise both masks. Latency changes between back-to-back reads check that each burst keeps its own timing.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  localparam int DQ_W       = 16;
  localparam int LANES      = 2;
  localparam int BYTE_W     = DQ_W / LANES;
  localparam int BL_LOG_MAX = 3;
  localparam int BL_MAX     = 1 << BL_LOG_MAX;
  localparam int CL_MAX     = 3;
  localparam int WIN        = CL_MAX + BL_MAX - 1;
  localparam int BLC_W      = $clog2(BL_LOG_MAX + 1);

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_STOP  = 2'd3
  } op_e;
endpackage

// File: rtl/sdp_rd_track.sv
module sdp_rd_track
  import sdp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             trunc,
  input  logic             cl3,
  input  logic [BLC_W-1:0] bl_code,
  output logic [WIN-1:0]   due
);
  // due[j] marks a read word expected j cycles from now
  int cl;
  int blen;
  logic [WIN-1:0] nxt;

  always_comb begin
    cl   = cl3 ? CL_MAX : CL_MAX - 1;
    blen = 1 << bl_code;
  end

  for (genvar j = 0; j < WIN; j++) begin : g_slot
    logic from_up;
    logic keep;
    logic fresh;
    if (j + 1 < WIN) begin : g_mid
      assign from_up = due[j+1];
    end else begin : g_end
      assign from_up = 1'b0;
    end
    // words already inside the memory's latency pipe survive a cut
    assign keep   = (j < cl - 1);
    assign fresh  = load && (j >= cl - 1) && (j <= cl + blen - 2);
    assign nxt[j] = (trunc ? (from_up & keep) : from_up) | fresh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) due <= '0;
    else        due <= nxt;
  end

  // R6
  new_burst_cl2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !cl3) |=> due[1]);
  // R6
  new_burst_cl3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && cl3) |=> due[2]);
  // R7
  cut_cl2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trunc && !load && !cl3) |=> (due[WIN-1:1] == '0));
  // R7
  cut_cl3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trunc && !load && cl3) |=> (due[WIN-1:2] == '0));
endmodule

// File: rtl/sdp_wr_track.sv
module sdp_wr_track
  import sdp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             kill,
  input  logic [BLC_W-1:0] bl_code,
  output logic             beat
);
  logic [BL_LOG_MAX:0] left;
  logic [BL_LOG_MAX:0] span;
  logic [BL_LOG_MAX:0] span_m1;

  assign span    = {{BL_LOG_MAX{1'b0}}, 1'b1} << bl_code;
  assign span_m1 = span - 1'b1;
  assign beat    = start | ((left != '0) & ~kill);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left <= '0;
    else if (start)        left <= span_m1;
    else if (kill)         left <= '0;
    else if (left != '0)   left <= left - 1'b1;
  end

  // R3
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (left != '0 && !start && !kill) |=> (left == $past(left) - 1'b1));
  // R8
  kill_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kill && !start) |=> (beat == start));
endmodule

// File: rtl/sdp_lane_gate.sv
module sdp_lane_gate
  import sdp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] dqm_now,
  input  logic             due_now,
  output logic [LANES-1:0] hist1,
  output logic [LANES-1:0] hist2,
  output logic [LANES-1:0] lane_en
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic s1;
    logic s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= dqm_now[i];
        s2 <= s1;
      end
    end
    assign hist1[i]   = s1;
    assign hist2[i]   = s2;
    assign lane_en[i] = due_now & ~s2;

    // R5
    mask_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane_en[i] |-> !$past(dqm_now[i], 2));
  end
endmodule

// File: rtl/sdram_dp_timer.sv
module sdram_dp_timer
  import sdp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmd_op,
  input  logic             cas3,
  input  logic [BLC_W-1:0] bl_code,
  input  logic [LANES-1:0] rmask,
  input  logic [DQ_W-1:0]  wd_data,
  input  logic             wd_valid,
  output logic             wd_ready,
  input  logic [LANES-1:0] wmask,
  output logic [DQ_W-1:0]  dq_out,
  output logic             dq_oe,
  output logic [LANES-1:0] dqm,
  input  logic [DQ_W-1:0]  dq_in,
  output logic [DQ_W-1:0]  rd_data,
  output logic [LANES-1:0] rd_lane,
  output logic             rd_valid,
  output logic             wr_clear
);
  localparam logic [LANES-1:0] ALL_MASK = {LANES{1'b1}};

  op_e op;
  logic is_rd, is_wr, is_st, wr_ok, beat;
  logic [WIN-1:0]   due;
  logic [LANES-1:0] h1, h2;

  assign op    = op_e'(cmd_op);
  assign is_rd = (op == OP_READ);
  assign is_wr = (op == OP_WRITE);
  assign is_st = (op == OP_STOP);

  // words still in the memory's output pipe that no mask can stop
  assign wr_clear = !(due[0] && h2 != ALL_MASK)
                 && !(due[1] && h1 != ALL_MASK)
                 && !(cas3 && due[2]);
  assign wr_ok = is_wr && wr_clear;

  sdp_rd_track u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (is_rd),
    .trunc   (is_rd | is_st | wr_ok),
    .cl3     (cas3),
    .bl_code (bl_code),
    .due     (due)
  );

  sdp_wr_track u_wr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (wr_ok),
    .kill    (is_rd | is_st),
    .bl_code (bl_code),
    .beat    (beat)
  );

  assign dqm = beat ? (wmask | {LANES{~wd_valid}}) : rmask;

  sdp_lane_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .dqm_now (dqm),
    .due_now (due[0]),
    .hist1   (h1),
    .hist2   (h2),
    .lane_en (rd_lane)
  );

  assign rd_valid = due[0];
  assign wd_ready = beat;
  assign dq_oe    = beat;
  assign dq_out   = beat ? wd_data : '0;

  for (genvar i = 0; i < LANES; i++) begin : g_rdata
    assign rd_data[i*BYTE_W +: BYTE_W] = rd_lane[i] ? dq_in[i*BYTE_W +: BYTE_W] : '0;
  end

  // R11
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe && (rd_lane != '0)));
  // R10
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_clear |-> !dq_oe);
  // R8
  read_kills_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd || is_st) |-> !dq_oe);
  // R1
  burst_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> ($past(cmd_op, 2) == OP_READ || $past(cmd_op, 3) == OP_READ));
endmodule

// File: tb/sdram_dp_timer_tb.sv
module sdram_dp_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic        cas3 = 1'b0;
  logic [1:0]  bl_code = 2'd0;
  logic [1:0]  rmask = 2'd0;
  logic [15:0] wd_data = 16'd0;
  logic        wd_valid = 1'b0;
  logic        wd_ready;
  logic [1:0]  wmask = 2'd0;
  logic [15:0] dq_out;
  logic        dq_oe;
  logic [1:0]  dqm;
  logic [15:0] dq_in = 16'd0;
  logic [15:0] rd_data;
  logic [1:0]  rd_lane;
  logic        rd_valid;
  logic        wr_clear;

  sdram_dp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cas3(cas3), .bl_code(bl_code),
    .rmask(rmask), .wd_data(wd_data), .wd_valid(wd_valid), .wd_ready(wd_ready),
    .wmask(wmask), .dq_out(dq_out), .dq_oe(dq_oe), .dqm(dqm), .dq_in(dq_in),
    .rd_data(rd_data), .rd_lane(rd_lane), .rd_valid(rd_valid), .wr_clear(wr_clear)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  int t = 0;
  int wr_end = 0;
  bit done = 1'b0;
  bit rd_due [0:4095];
  logic [1:0] dqm_h [0:4095];

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s cycle=%0d actual=%0h expected=%0h", tag, t, act, exp);
    end
  endtask

  task automatic cut_from(input int k0);
    for (int k = k0; k < k0 + 16; k++) rd_due[k] = 1'b0;
  endtask

  task automatic step(input logic [1:0] op, input logic c3, input logic [1:0] blc,
                      input logic [1:0] rm, input logic [1:0] wm, input logic wv);
    int c, b;
    logic [1:0] h1, h2, edqm, elane;
    logic [15:0] erd;
    bit clr, beat, due_now;
    @(negedge clk);
    cmd_op = op; cas3 = c3; bl_code = blc; rmask = rm; wmask = wm; wd_valid = wv;
    wd_data = 16'($urandom); dq_in = 16'($urandom);
    #2;
    c = c3 ? 3 : 2;
    b = 1 << blc;
    h1 = (t >= 1) ? dqm_h[t-1] : 2'b00;
    h2 = (t >= 2) ? dqm_h[t-2] : 2'b00;
    due_now = rd_due[t];
    clr = !(rd_due[t] && h2 != 2'b11) && !(rd_due[t+1] && h1 != 2'b11) && !(c3 && rd_due[t+2]);
    chk("R10 wr_clear", int'(wr_clear), int'(clr));
    if (op == 2'd1) begin
      cut_from(t + c);
      for (int k = 0; k < b; k++) rd_due[t+c+k] = 1'b1;
      wr_end = t;
    end else if (op == 2'd3) begin
      cut_from(t + c);
      wr_end = t;
    end else if (op == 2'd2 && clr) begin
      cut_from(t + c);
      wr_end = t + b;
    end
    beat = (t < wr_end);
    edqm = beat ? (wm | {2{~wv}}) : rm;
    dqm_h[t] = edqm;
    elane = due_now ? ~h2 : 2'b00;
    erd = {elane[1] ? dq_in[15:8] : 8'h00, elane[0] ? dq_in[7:0] : 8'h00};
    // read window covers R1 R2 R6 R7
    chk("R1 R2 R6 R7 rd_valid", int'(rd_valid), int'(due_now));
    chk("R5 rd_lane", int'(rd_lane), int'(elane));
    chk("R5 rd_data", int'(rd_data), int'(erd));
    // write window covers R3 R8 R9
    chk("R3 R8 R9 dq_oe", int'(dq_oe), int'(beat));
    chk("R3 wd_ready", int'(wd_ready), int'(beat));
    if (beat) begin
      chk("R3 dq_out", int'(dq_out), int'(wd_data));
      chk("R4 dqm", int'(dqm), int'(edqm));
    end else begin
      chk("R13 dqm", int'(dqm), int'(edqm));
    end
    chk("R11 exclusive", int'(dq_oe && (rd_lane != 2'b00)), 0);
    t++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(2'd0, 1'b0, 2'd0, 2'b00, 2'b00, 1'b1);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < 4096; k++) begin
      rd_due[k] = 1'b0;
      dqm_h[k] = 2'b00;
    end
    repeat (3) @(negedge clk);
    #2;
    // R12 reset state
    chk("R12 rd_valid", int'(rd_valid), 0);
    chk("R12 rd_lane", int'(rd_lane), 0);
    chk("R12 dq_oe", int'(dq_oe), 0);
    chk("R12 wd_ready", int'(wd_ready), 0);
    chk("R12 wr_clear", int'(wr_clear), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2: single bursts at both latencies
    step(2'd1, 1'b0, 2'd2, 2'b00, 2'b00, 1'b1); idle(8);
    step(2'd1, 1'b1, 2'd3, 2'b00, 2'b00, 1'b1); idle(12);
    // R6: read interrupted by read, latency changes
    step(2'd1, 1'b1, 2'd3, 2'b00, 2'b00, 1'b1); idle(3);
    step(2'd1, 1'b0, 2'd1, 2'b00, 2'b00, 1'b1); idle(8);
    // R7: burst stop during a read
    step(2'd1, 1'b0, 2'd3, 2'b00, 2'b00, 1'b1); idle(2);
    step(2'd3, 1'b0, 2'd0, 2'b00, 2'b00, 1'b1); idle(6);
    // R4: write with byte masks and an empty stream beat
    step(2'd2, 1'b0, 2'd2, 2'b00, 2'b01, 1'b1);
    step(2'd0, 1'b0, 2'd0, 2'b00, 2'b10, 1'b1);
    step(2'd0, 1'b0, 2'd0, 2'b00, 2'b00, 1'b0);
    step(2'd0, 1'b0, 2'd0, 2'b00, 2'b00, 1'b1); idle(3);
    // R8: write cut by read
    step(2'd2, 1'b0, 2'd3, 2'b00, 2'b00, 1'b1); idle(2);
    step(2'd1, 1'b0, 2'd2, 2'b00, 2'b00, 1'b1); idle(8);
    // R9: write restarted by write
    step(2'd2, 1'b0, 2'd2, 2'b00, 2'b00, 1'b1); idle(1);
    step(2'd2, 1'b0, 2'd1, 2'b00, 2'b00, 1'b1); idle(5);
    // R10: refused write, then a turnaround with masks raised ahead
    step(2'd1, 1'b1, 2'd3, 2'b00, 2'b00, 1'b1); idle(1);
    step(2'd2, 1'b0, 2'd2, 2'b00, 2'b00, 1'b1); idle(12);
    step(2'd1, 1'b0, 2'd2, 2'b00, 2'b00, 1'b1);
    step(2'd0, 1'b0, 2'd0, 2'b11, 2'b00, 1'b1);
    step(2'd0, 1'b0, 2'd0, 2'b11, 2'b00, 1'b1);
    step(2'd2, 1'b0, 2'd2, 2'b00, 2'b00, 1'b1); idle(6);
    // R5: partial read lanes
    step(2'd1, 1'b1, 2'd2, 2'b00, 2'b00, 1'b1);
    step(2'd0, 1'b0, 2'd0, 2'b00, 2'b00, 1'b1);
    step(2'd0, 1'b0, 2'd0, 2'b10, 2'b00, 1'b1);
    step(2'd0, 1'b0, 2'd0, 2'b01, 2'b00, 1'b1); idle(6);

    for (int n = 0; n < 2500; n++) begin
      int r;
      logic [1:0] op, rm;
      r = $urandom_range(0, 99);
      op = (r < 50) ? 2'd0 : (r < 70) ? 2'd1 : (r < 90) ? 2'd2 : 2'd3;
      rm = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00;
      step(op, 1'($urandom), 2'($urandom), rm, 2'($urandom), ($urandom_range(0, 7) != 0));
    end
    idle(16);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule